// File: doc/BRIEF.md
# Dual Audio Sample FIFO with Level Requests

This block holds outgoing and incoming audio words for a serial audio port. A transmit queue is filled by the processor and drained by the serial framer. A receive queue is filled by the framer and drained by the processor. Each queue holds 16 words of 32 bits. The processor side sees the word at the head of each queue without delay, and a pop strobe removes that word. Both occupancy counts are available as 5-bit values.

Two request flags tell software when to act. The receive request is raised once the receive queue holds more words than a programmable 4-bit level. The transmit request is raised once the free space in the transmit queue exceeds its own programmable 4-bit level. Four error conditions are detected and held until software clears them: overflow and underflow in each direction. Each queue can be emptied on its own. An optional byte exchange can be applied to the processor-side data, and a single interrupt line combines all six flags, each under its own enable.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both counts are 0, all four error flags and the receive request are 0, the head outputs read 0, the interrupt is 0, and the transmit request is 1.
- R2: Each queue returns words in the order they were accepted. Its count rises by one for each accepted push, falls by one for each accepted pop, and lies in the range 0 to 16. The head word is visible on the data output in the same cycle as the pop that removes it.
- R3: A push into a full queue, with no accepted pop in the same cycle, is discarded and sets that direction's overflow flag one cycle later.
- R4: A pop from an empty queue returns zero on the data output in that cycle and sets that direction's underflow flag one cycle later.
- R5: The receive request equals 1 exactly when the receive count is at least the receive level plus one.
- R6: The transmit request equals 1 exactly when 16 minus the transmit count is at least the transmit level plus one.
- R7: While a queue's clear input is high, its count becomes 0 on the next edge, and its push and pop strobes are ignored without setting any error flag.
- R8: Error flags are sticky and are cleared only by their own clear strobe. If a new error occurs in the same cycle as its clear strobe, the flag stays set.
- R9: When byte exchange is enabled, the processor-side words are reordered on write and on read so that bits 31:24 and 23:16 trade places and bits 15:8 and 7:0 trade places. Framer-side data is never reordered.
- R10: The interrupt is the OR of six terms. Each term is one flag ANDed with its own enable. The six flags are receive request, transmit request, receive overflow, receive underflow, transmit overflow and transmit underflow.
- R11: A push and an accepted pop in the same cycle on a full queue are both accepted, the count stays at 16 and no overflow is flagged. On an empty queue, the push is accepted and the pop underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_tx_push | input | 1 | Processor writes a word into the transmit queue |
| cpu_tx_data | input | 32 | Processor word to transmit |
| cpu_rx_pop | input | 1 | Processor removes the receive head word |
| cpu_rx_data | output | 32 | Receive head word, processor view (0 when empty) |
| fr_tx_pop | input | 1 | Framer removes the transmit head word |
| fr_tx_data | output | 32 | Transmit head word for the framer (0 when empty) |
| fr_rx_push | input | 1 | Framer writes a received word |
| fr_rx_data | input | 32 | Received word from the framer |
| tx_fifo_clr | input | 1 | Hold high to empty the transmit queue |
| rx_fifo_clr | input | 1 | Hold high to empty the receive queue |
| byte_swap_en | input | 1 | Enables the byte exchange on the processor side |
| rx_level | input | 4 | Receive request level |
| tx_level | input | 4 | Transmit request level |
| ie_rx_req | input | 1 | Interrupt enable for the receive request |
| ie_tx_req | input | 1 | Interrupt enable for the transmit request |
| ie_rx_ovf | input | 1 | Interrupt enable for receive overflow |
| ie_rx_unf | input | 1 | Interrupt enable for receive underflow |
| ie_tx_ovf | input | 1 | Interrupt enable for transmit overflow |
| ie_tx_unf | input | 1 | Interrupt enable for transmit underflow |
| clr_rx_ovf | input | 1 | Clear strobe for receive overflow |
| clr_rx_unf | input | 1 | Clear strobe for receive underflow |
| clr_tx_ovf | input | 1 | Clear strobe for transmit overflow |
| clr_tx_unf | input | 1 | Clear strobe for transmit underflow |
| tx_count | output | 5 | Words held in the transmit queue |
| rx_count | output | 5 | Words held in the receive queue |
| rx_req | output | 1 | Receive request flag |
| tx_req | output | 1 | Transmit request flag |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| tx_unf | output | 1 | Sticky transmit underflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: 32-bit words, a depth of 16 and 4-bit levels. Because the depth is small, directed phases fill and drain each queue past both ends in a few dozen cycles. This places every level value from 0 to 15 next to the full and empty counts, so the boundaries of the request comparison are reached, including a transmit level of 15 that is met only when the queue is empty. A long random phase mixes clears, simultaneous push and pop at both limits, clear strobes that coincide with new errors, and byte-exchange toggles between the write and the read of the same word.

// File: rtl/afp_pkg.sv
package afp_pkg;
    localparam int ERR_RX_OVF = 0;
    localparam int ERR_RX_UNF = 1;
    localparam int ERR_TX_OVF = 2;
    localparam int ERR_TX_UNF = 3;
    localparam int ERR_NUM    = 4;
endpackage

// File: rtl/afp_swap.sv
module afp_swap #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HALVES = DATA_W / 16;

    logic [DATA_W-1:0] swapped;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign swapped[h*16 +: 8]     = din[h*16 + 8 +: 8];
        assign swapped[h*16 + 8 +: 8] = din[h*16 +: 8];
    end

    assign dout = en ? swapped : din;

    initial begin
        AST_WORD_IN_HALVES: assert (DATA_W % 16 == 0); // R9
    end
endmodule

// File: rtl/afp_fifo.sv
module afp_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_evt,
    output logic              unf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic empty, full, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == FULL_CNT);
        do_pop  = pop && !clr && !empty;
        do_push = push && !clr && (!full || do_pop);
        ovf_evt = push && !clr && !do_push;
        unf_evt = pop && !clr && empty;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            if (do_pop)  st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= push_data;
    end

    assign pop_data = empty ? '0 : mem[st_q.rd];
    assign count    = st_q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1)
                 || (count == $past(count) - 1'b1)); // R2
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> count == FULL_CNT); // R3
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |-> pop_data == '0); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R7
    AST_CLEAR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !ovf_evt && !unf_evt); // R7
endmodule

// File: rtl/afp_err_flags.sv
module afp_err_flags #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] evt,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] flag
);
    typedef struct packed {
        logic [NUM-1:0] flag;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    for (genvar i = 0; i < NUM; i++) begin : g_chk
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            flag[i] && !clr[i] |=> flag[i]); // R8
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag[i]); // R8
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !evt[i] |=> !flag[i]); // R8
    end
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 4,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tx_push,
    input  logic [DATA_W-1:0] cpu_tx_data,
    input  logic              cpu_rx_pop,
    output logic [DATA_W-1:0] cpu_rx_data,
    input  logic              fr_tx_pop,
    output logic [DATA_W-1:0] fr_tx_data,
    input  logic              fr_rx_push,
    input  logic [DATA_W-1:0] fr_rx_data,
    input  logic              tx_fifo_clr,
    input  logic              rx_fifo_clr,
    input  logic              byte_swap_en,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              ie_rx_req,
    input  logic              ie_tx_req,
    input  logic              ie_rx_ovf,
    input  logic              ie_rx_unf,
    input  logic              ie_tx_ovf,
    input  logic              ie_tx_unf,
    input  logic              clr_rx_ovf,
    input  logic              clr_rx_unf,
    input  logic              clr_tx_ovf,
    input  logic              clr_tx_unf,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_req,
    output logic              tx_req,
    output logic              rx_ovf,
    output logic              rx_unf,
    output logic              tx_ovf,
    output logic              tx_unf,
    output logic              irq
);
    import afp_pkg::*;

    localparam int CMP_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;
    localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

    logic [DATA_W-1:0] tx_wr_word, rx_head_raw;
    logic              tx_ovf_evt, tx_unf_evt, rx_ovf_evt, rx_unf_evt;
    logic [ERR_NUM-1:0] err_evt, err_clr, err_flag;
    logic [CMP_W-1:0]  tx_free, rx_need, tx_need;

    afp_swap #(.DATA_W(DATA_W)) i_swap_wr (
        .en(byte_swap_en), .din(cpu_tx_data), .dout(tx_wr_word));

    afp_swap #(.DATA_W(DATA_W)) i_swap_rd (
        .en(byte_swap_en), .din(rx_head_raw), .dout(cpu_rx_data));

    afp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_fifo_clr),
        .push(cpu_tx_push), .push_data(tx_wr_word),
        .pop(fr_tx_pop), .pop_data(fr_tx_data),
        .count(tx_count), .ovf_evt(tx_ovf_evt), .unf_evt(tx_unf_evt));

    afp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_fifo_clr),
        .push(fr_rx_push), .push_data(fr_rx_data),
        .pop(cpu_rx_pop), .pop_data(rx_head_raw),
        .count(rx_count), .ovf_evt(rx_ovf_evt), .unf_evt(rx_unf_evt));

    always_comb begin
        err_evt             = '0;
        err_clr             = '0;
        err_evt[ERR_RX_OVF] = rx_ovf_evt;
        err_evt[ERR_RX_UNF] = rx_unf_evt;
        err_evt[ERR_TX_OVF] = tx_ovf_evt;
        err_evt[ERR_TX_UNF] = tx_unf_evt;
        err_clr[ERR_RX_OVF] = clr_rx_ovf;
        err_clr[ERR_RX_UNF] = clr_rx_unf;
        err_clr[ERR_TX_OVF] = clr_tx_ovf;
        err_clr[ERR_TX_UNF] = clr_tx_unf;
    end

    afp_err_flags #(.NUM(ERR_NUM)) i_err (
        .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(err_clr), .flag(err_flag));

    assign rx_ovf = err_flag[ERR_RX_OVF];
    assign rx_unf = err_flag[ERR_RX_UNF];
    assign tx_ovf = err_flag[ERR_TX_OVF];
    assign tx_unf = err_flag[ERR_TX_UNF];

    always_comb begin
        tx_free = DEPTH_C - CMP_W'(tx_count);
        rx_need = CMP_W'(rx_level) + 1'b1;
        tx_need = CMP_W'(tx_level) + 1'b1;
        rx_req  = CMP_W'(rx_count) >= rx_need;
        tx_req  = tx_free >= tx_need;
        irq     = (rx_req & ie_rx_req) | (tx_req & ie_tx_req)
                | (rx_ovf & ie_rx_ovf) | (rx_unf & ie_rx_unf)
                | (tx_ovf & ie_tx_ovf) | (tx_unf & ie_tx_unf);
    end

    AST_RX_REQ_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == CNT_W'(DEPTH) |-> rx_req); // R5
    AST_TX_REQ_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count == '0 |-> tx_req); // R6
    AST_IRQ_FROM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && ie_tx_ovf) || (rx_unf && ie_rx_unf) |-> irq); // R10
endmodule

// File: tb/test_audio_fifo_pair.sv
`timescale 1ns/1ps
module test_audio_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tx_push = 0, cpu_rx_pop = 0, fr_tx_pop = 0, fr_rx_push = 0;
    logic [31:0] cpu_tx_data = '0, fr_rx_data = '0;
    logic [31:0] cpu_rx_data, fr_tx_data;
    logic        tx_fifo_clr = 0, rx_fifo_clr = 0, byte_swap_en = 0;
    logic [3:0]  rx_level = '0, tx_level = '0;
    logic        ie_rx_req = 0, ie_tx_req = 0, ie_rx_ovf = 0, ie_rx_unf = 0;
    logic        ie_tx_ovf = 0, ie_tx_unf = 0;
    logic        clr_rx_ovf = 0, clr_rx_unf = 0, clr_tx_ovf = 0, clr_tx_unf = 0;
    logic [4:0]  tx_count, rx_count;
    logic        rx_req, tx_req, rx_ovf, rx_unf, tx_ovf, tx_unf, irq;

    int nchk = 0;
    int nerr = 0;

    bit [31:0] txq[$];
    bit [31:0] rxq[$];
    bit m_rx_ovf = 0, m_rx_unf = 0, m_tx_ovf = 0, m_tx_unf = 0;

    always #2 clk = ~clk;

    audio_fifo_pair i_audio_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
        .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data),
        .fr_tx_pop(fr_tx_pop), .fr_tx_data(fr_tx_data),
        .fr_rx_push(fr_rx_push), .fr_rx_data(fr_rx_data),
        .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr),
        .byte_swap_en(byte_swap_en), .rx_level(rx_level), .tx_level(tx_level),
        .ie_rx_req(ie_rx_req), .ie_tx_req(ie_tx_req), .ie_rx_ovf(ie_rx_ovf),
        .ie_rx_unf(ie_rx_unf), .ie_tx_ovf(ie_tx_ovf), .ie_tx_unf(ie_tx_unf),
        .clr_rx_ovf(clr_rx_ovf), .clr_rx_unf(clr_rx_unf),
        .clr_tx_ovf(clr_tx_ovf), .clr_tx_unf(clr_tx_unf),
        .tx_count(tx_count), .rx_count(rx_count), .rx_req(rx_req), .tx_req(tx_req),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ovf(tx_ovf), .tx_unf(tx_unf), .irq(irq));

    function automatic bit [31:0] exch(bit [31:0] w);
        bit [7:0] b0, b1, b2, b3;
        b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
        return {b2, b3, b0, b1};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cpu_tx_push = 0; cpu_rx_pop = 0; fr_tx_pop = 0; fr_rx_push = 0;
        tx_fifo_clr = 0; rx_fifo_clr = 0;
        clr_rx_ovf = 0; clr_rx_unf = 0; clr_tx_ovf = 0; clr_tx_unf = 0;
    endtask

    // Called at a falling edge with inputs already set: compares, then advances the model.
    task automatic step();
        bit e_rxreq, e_txreq, e_irq;
        bit [31:0] e_rxd, e_txd;
        bit tx_pop_ok, tx_push_ok, rx_pop_ok, rx_push_ok;
        bit tx_o, tx_u, rx_o, rx_u;
        bit [31:0] wword;
        #1;
        e_rxreq = rxq.size() >= int'(rx_level) + 1;                 // R5
        e_txreq = (16 - txq.size()) >= int'(tx_level) + 1;          // R6
        e_rxd   = (rxq.size() > 0) ? (byte_swap_en ? exch(rxq[0]) : rxq[0]) : 32'h0;
        e_txd   = (txq.size() > 0) ? txq[0] : 32'h0;
        e_irq   = (e_rxreq && ie_rx_req) || (e_txreq && ie_tx_req) ||
                  (m_rx_ovf && ie_rx_ovf) || (m_rx_unf && ie_rx_unf) ||
                  (m_tx_ovf && ie_tx_ovf) || (m_tx_unf && ie_tx_unf);
        chk("R2 tx_count", tx_count, txq.size());
        chk("R2 rx_count", rx_count, rxq.size());
        chk("R5 rx_req", rx_req, e_rxreq);
        chk("R6 tx_req", tx_req, e_txreq);
        chk("R2 R4 R9 cpu_rx_data", cpu_rx_data, e_rxd);
        chk("R2 R4 fr_tx_data", fr_tx_data, e_txd);
        chk("R3 R8 rx_ovf", rx_ovf, m_rx_ovf);
        chk("R4 R8 rx_unf", rx_unf, m_rx_unf);
        chk("R3 R8 tx_ovf", tx_ovf, m_tx_ovf);
        chk("R4 R8 tx_unf", tx_unf, m_tx_unf);
        chk("R10 irq", irq, e_irq);
        @(posedge clk);
        tx_o = 0; tx_u = 0; rx_o = 0; rx_u = 0;
        wword = byte_swap_en ? exch(cpu_tx_data) : cpu_tx_data;
        if (tx_fifo_clr) txq.delete();
        else begin
            tx_pop_ok  = fr_tx_pop && txq.size() > 0;
            tx_u       = fr_tx_pop && txq.size() == 0;
            tx_push_ok = cpu_tx_push && (txq.size() < 16 || tx_pop_ok);
            tx_o       = cpu_tx_push && !tx_push_ok;
            if (tx_pop_ok) void'(txq.pop_front());
            if (tx_push_ok) txq.push_back(wword);
        end
        if (rx_fifo_clr) rxq.delete();
        else begin
            rx_pop_ok  = cpu_rx_pop && rxq.size() > 0;
            rx_u       = cpu_rx_pop && rxq.size() == 0;
            rx_push_ok = fr_rx_push && (rxq.size() < 16 || rx_pop_ok);
            rx_o       = fr_rx_push && !rx_push_ok;
            if (rx_pop_ok) void'(rxq.pop_front());
            if (rx_push_ok) rxq.push_back(fr_rx_data);
        end
        m_rx_ovf = (m_rx_ovf && !clr_rx_ovf) || rx_o;
        m_rx_unf = (m_rx_unf && !clr_rx_unf) || rx_u;
        m_tx_ovf = (m_tx_ovf && !clr_tx_ovf) || tx_o;
        m_tx_unf = (m_tx_unf && !clr_tx_unf) || tx_u;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 errors", {rx_ovf, rx_unf, tx_ovf, tx_unf}, 0);
        chk("R1 irq", irq, 0);
        chk("R1 heads", cpu_rx_data | fr_tx_data, 0);
        @(negedge clk);

        // Transmit path: fill, overflow, drain, underflow
        tx_level = 4'd3; rx_level = 4'd2;
        for (int i = 0; i < 16; i++) begin
            idle(); cpu_tx_push = 1; cpu_tx_data = 32'hA000_0000 + i; step();
        end
        idle(); cpu_tx_push = 1; cpu_tx_data = 32'hDEAD_BEEF; step();
        idle(); step();
        chk("R3 tx_ovf after push to full", tx_ovf, 1);
        chk("R3 tx_count stays full", tx_count, 16);
        for (int i = 0; i < 16; i++) begin idle(); fr_tx_pop = 1; step(); end
        idle(); fr_tx_pop = 1; step();
        idle(); step();
        chk("R4 tx_unf after pop from empty", tx_unf, 1);
        idle(); clr_tx_ovf = 1; step();
        idle(); step();
        chk("R8 tx_ovf cleared", tx_ovf, 0);
        chk("R8 tx_unf kept", tx_unf, 1);

        // Receive path with byte exchange
        byte_swap_en = 1;
        for (int i = 0; i < 17; i++) begin
            idle(); fr_rx_push = 1; fr_rx_data = 32'h1122_3300 + i; step();
        end
        idle(); step();
        chk("R9 swapped head", cpu_rx_data, 32'h2211_0033);
        for (int i = 0; i < 17; i++) begin idle(); cpu_rx_pop = 1; step(); end
        idle(); step();

        // Swap on transmit write, framer side raw
        idle(); cpu_tx_push = 1; cpu_tx_data = 32'hAABB_CCDD; step();
        idle(); step();
        chk("R9 tx word exchanged", fr_tx_data, 32'hBBAA_DDCC);
        byte_swap_en = 0;

        // Simultaneous push and pop at limits
        idle(); clr_rx_ovf = 1; clr_rx_unf = 1; clr_tx_unf = 1; step();
        for (int i = 0; i < 16; i++) begin
            idle(); fr_rx_push = 1; fr_rx_data = 32'h5500_0000 + i; step();
        end
        idle(); fr_rx_push = 1; cpu_rx_pop = 1; fr_rx_data = 32'h77; step();
        idle(); step();
        chk("R11 full push+pop count", rx_count, 16);
        chk("R11 full push+pop no ovf", rx_ovf, 0);
        idle(); rx_fifo_clr = 1; step();
        idle(); fr_rx_push = 1; cpu_rx_pop = 1; fr_rx_data = 32'h99; step();
        idle(); step();
        chk("R11 empty push kept", rx_count, 1);
        chk("R11 empty pop underflows", rx_unf, 1);

        // Clear while strobing
        for (int i = 0; i < 5; i++) begin
            idle(); cpu_tx_push = 1; cpu_tx_data = i; step();
        end
        idle(); clr_tx_unf = 1; clr_tx_ovf = 1; step();
        idle(); tx_fifo_clr = 1; cpu_tx_push = 1; fr_tx_pop = 1; step();
        idle(); tx_fifo_clr = 1; fr_tx_pop = 1; step();
        idle(); step();
        chk("R7 tx cleared", tx_count, 0);
        chk("R7 no error during clear", {tx_ovf, tx_unf}, 0);

        // Set wins over clear
        idle(); fr_tx_pop = 1; clr_tx_unf = 1; step();
        idle(); step();
        chk("R8 set wins", tx_unf, 1);

        // Level sweeps and interrupt enables
        ie_rx_req = 1; ie_tx_req = 1; ie_rx_ovf = 1; ie_rx_unf = 1; ie_tx_ovf = 1; ie_tx_unf = 1;
        for (int lv = 0; lv < 16; lv++) begin
            rx_level = lv[3:0]; tx_level = 4'(15 - lv);
            idle(); fr_rx_push = 1; cpu_tx_push = 1; step();
        end

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            cpu_tx_push = ($urandom % 2) == 0;
            fr_tx_pop   = ($urandom % 3) == 0;
            fr_rx_push  = ($urandom % 3) == 0;
            cpu_rx_pop  = ($urandom % 2) == 0;
            cpu_tx_data = $urandom; fr_rx_data = $urandom;
            tx_fifo_clr = ($urandom % 60) == 0;
            rx_fifo_clr = ($urandom % 60) == 0;
            clr_rx_ovf = ($urandom % 8) == 0; clr_rx_unf = ($urandom % 8) == 0;
            clr_tx_ovf = ($urandom % 8) == 0; clr_tx_unf = ($urandom % 8) == 0;
            if (($urandom % 20) == 0) byte_swap_en = ~byte_swap_en;
            if (($urandom % 30) == 0) begin rx_level = 4'($urandom); tx_level = 4'($urandom); end
            if (($urandom % 25) == 0) {ie_rx_req, ie_tx_req, ie_rx_ovf, ie_rx_unf, ie_tx_ovf, ie_tx_unf} = 6'($urandom);
            step();
        end
        idle(); step();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule